// File: doc/BRIEF.md
# External Memory Strobe Sequencer with Selectable Read Timing

This block turns single-beat read and write requests from an internal request/acknowledge port into active-low chip-select, read-strobe and write-strobe waveforms on an external memory bus. It runs on a clock at twice the master bus rate. A phase bit splits every master cycle into a first half and a second half, so strobes can be placed on half-cycle boundaries. The master-cycle phase is brought out as `mck_o`, which is high during the first half.

A mode bit picks one of two read timings for every device. Standard timing holds the read strobe off during the first half of the access, so the previous access has time to clear the bus. Early timing asserts it from the first half, which leaves the memory more time to answer. In early mode, the chip select and read strobe of the last device read stay low while the bus is idle. A following read of the same device therefore sees an unbroken strobe. Early mode also inserts one bus-quiet master cycle when a read directly follows a write. A per-request count of extra wait states stretches the strobe-active period by whole master cycles.

Top module: `ebus_rdstrobe_seq`

## Requirements
- R1: After reset, the mode is standard, every chip select and both strobes are high (inactive), the acknowledge is low and the data bus is released (high impedance).
- R2: In standard mode, a read drives the selected chip select (one-hot low, bit index equal to the device number) low for all 2*(1+W) half-cycles of the access, where W is the extra-wait count. The read strobe stays high in the first half-cycle and is low for the remaining 2*(1+W)-1 half-cycles.
- R3: In either mode, a write keeps the read strobe high, holds the write strobe high in the first half-cycle and low for the remaining 2*(1+W)-1 half-cycles, and drives the write data on the data bus during the access.
- R4: In early mode, a read holds the read strobe low for all 2*(1+W) half-cycles, starting with the first half of the access.
- R5: After an early-mode read completes, that device's chip select and the read strobe stay low while the bus is idle. The next access releases them. Switching the mode to standard while idle also releases them.
- R6: In early mode, a read whose previous access was a write is preceded by one turnaround master cycle (two half-cycles) in which all chip selects and both strobes are high.
- R7: No turnaround cycle is inserted for a read after a read, a write after a read, a write after a write, or any access in standard mode.
- R8: The extra-wait count W sampled with the request lengthens the access by exactly W master cycles, in addition to any turnaround cycle.
- R9: The acknowledge is high for exactly one clock, in the clock right after the last half-cycle of the access. For a read, the returned data equals the bus data present in that last half-cycle.
- R10: `mck_o` toggles every clock. An accepted access always begins in a half-cycle with `mck_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, twice the master bus rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the read-timing mode bit |
| cfg_early | input | 1 | Mode value: 1 early read timing, 0 standard |
| req_valid | input | 1 | Access request, held until acknowledged |
| req_write | input | 1 | 1 write, 0 read |
| req_dev | input | DEVW | Target device index |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_xwait | input | WAITW | Extra wait states in master cycles |
| req_ack | output | 1 | One-clock completion pulse |
| req_rdata | output | DW | Read data captured at the end of the access |
| mck_o | output | 1 | Master-cycle phase, high in the first half |
| bus_ncs_n | output | NDEV | Active-low chip selects |
| bus_rd_n | output | 1 | Active-low read strobe / output enable |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_addr | output | AW | Address bus |
| bus_data | inout | DW | Bidirectional data bus |

## Verification
A lost or stale record of the previous access type shows up within the next early-mode read as a missing or extra two-half-cycle quiet gap, and as an acknowledge two clocks early or late. A wrong half-cycle marker or a wrong mode latch moves the read-strobe edge by half a master cycle in the first half-cycle of the access. A park flag that is not cleared leaves the read strobe low in the idle half-cycles before a write, or after a switch to standard mode, so it is visible before the next access begins. Errors in the wait counter change the number of strobe-low half-cycles and the acknowledge position in the same access.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TURN = 2'd1,
        ST_ACC  = 2'd2
    } bst_e;

endpackage

// File: rtl/ebus_mode_reg.sv
module ebus_mode_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic cfg_early,
    output logic early
);
    logic early_d, early_q;

    always_comb begin
        early_d = early_q;
        if (cfg_we) begin
            early_d = cfg_early;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            early_q <= 1'b0;
        end else begin
            early_q <= early_d;
        end
    end

    assign early = early_q;

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (early == $past(cfg_early))) else $error("mode load"); // R1
endmodule

// File: rtl/ebus_turn_det.sv
module ebus_turn_det (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic done_wr,
    input  logic early,
    input  logic req_write,
    output logic need_turn
);
    logic prev_wr_d, prev_wr_q;

    always_comb begin
        prev_wr_d = prev_wr_q;
        if (done) begin
            prev_wr_d = done_wr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_wr_q <= 1'b0;
        end else begin
            prev_wr_q <= prev_wr_d;
        end
    end

    assign need_turn = early && prev_wr_q && !req_write;

    AST_TURN_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_wr) |=> !need_turn) else $error("turn after read"); // R7
endmodule

// File: rtl/ebus_strobe_dec.sv
module ebus_strobe_dec
    import ebus_pkg::*;
#(
    parameter int NDEV = 4,
    parameter int DEVW = 2
) (
    input  bst_e            st,
    input  logic            first,
    input  logic            wr,
    input  logic            early,
    input  logic            park,
    input  logic [DEVW-1:0] dev,
    output logic [NDEV-1:0] ncs_n,
    output logic            rd_n,
    output logic            wr_n,
    output logic            oe
);
    logic sel_on;

    assign sel_on = (st == ST_ACC) || ((st == ST_IDLE) && park);

    for (genvar g = 0; g < NDEV; g++) begin : g_cs
        assign ncs_n[g] = !(sel_on && (dev == DEVW'(g)));
    end

    always_comb begin
        rd_n = 1'b1;
        wr_n = 1'b1;
        oe   = 1'b0;
        if (st == ST_ACC) begin
            if (wr) begin
                oe   = 1'b1;
                wr_n = first;
            end else begin
                rd_n = first && !early;
            end
        end else if ((st == ST_IDLE) && park) begin
            rd_n = 1'b0;
        end
    end
endmodule

// File: rtl/ebus_rdstrobe_seq.sv
module ebus_rdstrobe_seq
    import ebus_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int NDEV  = 4,
    parameter int WAITW = 3,
    localparam int DEVW = (NDEV > 1) ? $clog2(NDEV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_early,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [DEVW-1:0]  req_dev,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [WAITW-1:0] req_xwait,
    output logic             req_ack,
    output logic [DW-1:0]    req_rdata,
    output logic             mck_o,
    output logic [NDEV-1:0]  bus_ncs_n,
    output logic             bus_rd_n,
    output logic             bus_wr_n,
    output logic [AW-1:0]    bus_addr,
    inout  wire  [DW-1:0]    bus_data
);
    localparam int CNTW = WAITW + 1;

    typedef struct packed {
        bst_e             st;
        logic             ph;
        logic             first;
        logic             park;
        logic             wr;
        logic             early;
        logic [DEVW-1:0]  dev;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    wdata;
        logic [WAITW-1:0] xw;
        logic [CNTW-1:0]  cnt;
        logic             ack;
        logic [DW-1:0]    rdata;
    } seq_t;

    typedef struct packed {
        logic [NDEV-1:0] ncs_n;
        logic            rd_n;
        logic            wr_n;
        logic            oe;
    } out_t;

    seq_t seq_d, seq_q;
    out_t out_d, out_q;
    logic mode_early;
    logic need_turn;
    logic acc_done;

    ebus_mode_reg i_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_early(cfg_early),
        .early    (mode_early)
    );

    ebus_turn_det i_turn (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (acc_done),
        .done_wr  (seq_q.wr),
        .early    (mode_early),
        .req_write(req_write),
        .need_turn(need_turn)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.ph    = ~seq_q.ph;
        seq_d.ack   = 1'b0;
        seq_d.first = 1'b0;
        acc_done    = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (!mode_early) begin
                    seq_d.park = 1'b0;
                end
                if (seq_q.ph && req_valid) begin
                    seq_d.wr    = req_write;
                    seq_d.early = mode_early;
                    seq_d.dev   = req_dev;
                    seq_d.addr  = req_addr;
                    seq_d.wdata = req_wdata;
                    seq_d.xw    = req_xwait;
                    seq_d.park  = 1'b0;
                    if (need_turn) begin
                        seq_d.st  = ST_TURN;
                        seq_d.cnt = CNTW'(1);
                    end else begin
                        seq_d.st    = ST_ACC;
                        seq_d.cnt   = {req_xwait, 1'b1};
                        seq_d.first = 1'b1;
                    end
                end
            end
            ST_TURN: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st    = ST_ACC;
                    seq_d.cnt   = {seq_q.xw, 1'b1};
                    seq_d.first = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNTW'(1);
                end
            end
            ST_ACC: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.ack  = 1'b1;
                    seq_d.park = seq_q.early && !seq_q.wr;
                    acc_done   = 1'b1;
                    if (!seq_q.wr) begin
                        seq_d.rdata = bus_data;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt - CNTW'(1);
                end
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    ebus_strobe_dec #(
        .NDEV(NDEV),
        .DEVW(DEVW)
    ) i_dec (
        .st   (seq_d.st),
        .first(seq_d.first),
        .wr   (seq_d.wr),
        .early(seq_d.early),
        .park (seq_d.park),
        .dev  (seq_d.dev),
        .ncs_n(out_d.ncs_n),
        .rd_n (out_d.rd_n),
        .wr_n (out_d.wr_n),
        .oe   (out_d.oe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, default: '0};
            out_q <= '{ncs_n: '1, rd_n: 1'b1, wr_n: 1'b1, oe: 1'b0};
        end else begin
            seq_q <= seq_d;
            out_q <= out_d;
        end
    end

    assign req_ack   = seq_q.ack;
    assign req_rdata = seq_q.rdata;
    assign mck_o     = ~seq_q.ph;
    assign bus_ncs_n = out_q.ncs_n;
    assign bus_rd_n  = out_q.rd_n;
    assign bus_wr_n  = out_q.wr_n;
    assign bus_addr  = seq_q.addr;
    assign bus_data  = out_q.oe ? seq_q.wdata : {DW{1'bz}};

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack) else $error("ack width"); // R9
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~bus_ncs_n) <= 1) else $error("multi select"); // R2
    AST_RD_FALL_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rd_n) |-> (seq_q.early == mck_o)) else $error("rd edge phase"); // R4
    AST_WR_SECOND_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_wr_n) |-> !mck_o) else $error("wr edge phase"); // R3
    AST_NO_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && out_q.oe)) else $error("bus clash"); // R3
    AST_TURN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_TURN) |-> (&bus_ncs_n && bus_rd_n && bus_wr_n)) else $error("turn not quiet"); // R6
    AST_START_FIRST_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.first |-> mck_o) else $error("start phase"); // R10
endmodule

// File: tb/test_ebus_rdstrobe_seq.sv
module test_ebus_rdstrobe_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int NDEV = 4;
    localparam int WAITW = 3;
    localparam logic [15:0] MEMX = 16'h5A3C;

    typedef struct packed {
        logic        early;
        logic        wr;
        logic [1:0]  dev;
        logic [15:0] addr;
        logic [15:0] wd;
        logic [2:0]  xw;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VT [NV] = '{
        '{1'b0, 1'b0, 2'd0, 16'h0100, 16'h0000, 3'd0},
        '{1'b0, 1'b1, 2'd1, 16'h0204, 16'hBEEF, 3'd0},
        '{1'b0, 1'b0, 2'd1, 16'h0208, 16'h0000, 3'd1},
        '{1'b1, 1'b0, 2'd2, 16'h0310, 16'h0000, 3'd0},
        '{1'b1, 1'b0, 2'd2, 16'h0312, 16'h0000, 3'd0},
        '{1'b1, 1'b0, 2'd3, 16'h0420, 16'h0000, 3'd2},
        '{1'b1, 1'b1, 2'd3, 16'h0424, 16'h1234, 3'd0},
        '{1'b1, 1'b1, 2'd0, 16'h0030, 16'h55AA, 3'd1},
        '{1'b1, 1'b0, 2'd0, 16'h0034, 16'h0000, 3'd0},
        '{1'b1, 1'b0, 2'd1, 16'h0140, 16'h0000, 3'd1},
        '{1'b1, 1'b1, 2'd2, 16'h0250, 16'hC0DE, 3'd0},
        '{1'b1, 1'b0, 2'd2, 16'h0254, 16'h0000, 3'd3},
        '{1'b0, 1'b1, 2'd1, 16'h0160, 16'h7E57, 3'd0},
        '{1'b0, 1'b0, 2'd1, 16'h0164, 16'h0000, 3'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_early = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_dev = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [WAITW-1:0] req_xwait = '0;
    logic req_ack;
    logic [DW-1:0] req_rdata;
    logic mck_o;
    logic [NDEV-1:0] bus_ncs_n;
    logic bus_rd_n, bus_wr_n;
    logic [AW-1:0] bus_addr;
    wire [DW-1:0] bus_data;

    int checks = 0;
    int errors = 0;
    logic cur_early = 1'b0;
    logic prev_wr = 1'b0;
    logic prev_park = 1'b0;

    assign bus_data = (!bus_rd_n) ? (bus_addr ^ MEMX) : {DW{1'bz}};

    always #(CLK_PERIOD/2) clk = ~clk;

    ebus_rdstrobe_seq #(.AW(AW), .DW(DW), .NDEV(NDEV), .WAITW(WAITW)) i_ebus_rdstrobe_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_early(cfg_early),
        .req_valid(req_valid), .req_write(req_write), .req_dev(req_dev),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_xwait(req_xwait),
        .req_ack(req_ack), .req_rdata(req_rdata), .mck_o(mck_o),
        .bus_ncs_n(bus_ncs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_addr(bus_addr), .bus_data(bus_data)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_mode(input logic e);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_early = e;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
        cur_early = e;
    endtask

    task automatic run_vec(input vec_t v);
        logic exp_pk;
        int turn, start, halves, ack_k, rd_lo, wr_lo, cs_on;
        logic first_rd;
        logic [NDEV-1:0] sel;
        if (v.early != cur_early) set_mode(v.early);
        if (!mck_o) @(negedge clk);
        exp_pk = prev_park && cur_early;
        sel = ~(NDEV'(1) << v.dev);
        turn = (cur_early && prev_wr && !v.wr) ? 1 : 0;
        start = 2 + 2 * turn;
        halves = 2 * (1 + int'(v.xw));
        req_valid = 1'b1; req_write = v.wr; req_dev = v.dev;
        req_addr = v.addr; req_wdata = v.wd; req_xwait = v.xw;
        chk("R5", "park rd before accept", {31'd0, bus_rd_n}, {31'd0, !exp_pk});
        @(negedge clk);
        chk("R5", "park rd idle half", {31'd0, bus_rd_n}, {31'd0, !exp_pk});
        chk("R10", "idle half phase", {31'd0, mck_o}, 32'd0);
        ack_k = -1; rd_lo = 0; wr_lo = 0; cs_on = 0; first_rd = 1'bx;
        for (int k = 2; k < 80; k++) begin
            @(negedge clk);
            if (req_ack) begin
                ack_k = k;
                break;
            end
            if (k < start) begin
                chk("R6", "turn quiet", {27'd0, bus_ncs_n, bus_rd_n}, {27'd0, 4'hF, 1'b1});
            end else begin
                if (k == start) begin
                    first_rd = bus_rd_n;
                    chk("R10", "access starts first half", {31'd0, mck_o}, 32'd1);
                end
                if (!bus_rd_n) rd_lo++;
                if (!bus_wr_n) wr_lo++;
                if (bus_ncs_n == sel) cs_on++;
                if (v.wr && k == start + 1)
                    chk("R3", "write data on bus", {16'd0, bus_data}, {16'd0, v.wd});
            end
        end
        chk("R8", "ack position", ack_k, start + halves);
        chk("R2", "cs low halves", cs_on, halves);
        if (v.wr) begin
            chk("R3", "wr low halves", wr_lo, halves - 1);
            chk("R3", "rd high on write", rd_lo, 0);
        end else if (cur_early) begin
            chk("R4", "early rd low halves", rd_lo, halves);
            chk("R4", "early rd first half", {31'd0, first_rd}, 32'd0);
        end else begin
            chk("R2", "std rd low halves", rd_lo, halves - 1);
            chk("R2", "std rd first half", {31'd0, first_rd}, 32'd1);
        end
        if (!v.wr) chk("R9", "read data", {16'd0, req_rdata}, {16'd0, v.addr ^ MEMX});
        chk("R7", "turn only on early wr->rd", {31'd0, ack_k == 2 + halves}, {31'd0, turn == 0});
        req_valid = 1'b0;
        @(negedge clk);
        chk("R9", "ack one clock", {31'd0, req_ack}, 32'd0);
        prev_wr = v.wr;
        prev_park = !v.wr && cur_early;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic m0;
        repeat (3) @(negedge clk);
        chk("R1", "reset cs", {28'd0, bus_ncs_n}, 32'hF);
        chk("R1", "reset strobes", {30'd0, bus_rd_n, bus_wr_n}, 32'h3);
        chk("R1", "reset ack", {31'd0, req_ack}, 32'd0);
        chk("R1", "reset bus released", {31'd0, bus_data === 16'hzzzz}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        m0 = mck_o;
        @(negedge clk);
        chk("R10", "phase toggles", {31'd0, mck_o}, {31'd0, !m0});
        chk("R1", "idle after reset", {26'd0, bus_ncs_n, bus_rd_n, bus_wr_n}, {26'd0, 4'hF, 2'b11});
        for (int i = 0; i < NV; i++) run_vec(VT[i]);
        // R5: early read then a switch to standard releases the parked strobes
        run_vec('{1'b1, 1'b0, 2'd3, 16'h0777, 16'h0000, 3'd0});
        chk("R5", "parked rd while idle", {31'd0, bus_rd_n}, 32'd0);
        chk("R5", "parked cs while idle", {28'd0, bus_ncs_n}, 32'h7);
        set_mode(1'b0);
        chk("R5", "release rd on mode switch", {31'd0, bus_rd_n}, 32'd1);
        chk("R5", "release cs on mode switch", {28'd0, bus_ncs_n}, 32'hF);
        chk("R1", "bus released idle", {31'd0, bus_data === 16'hzzzz}, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule